// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller that opens only when three digits arrive in the right order and each one equals the matching digit of a stored combination. Each digit is offered on a data bus together with a one-cycle strobe. A small datapath does the checking. Three registers hold the combination, and a one-hot AND-OR selector routes the digit expected at the current step to an equality comparator. A finite-state controller walks through the three entry steps and then settles in either an open or an error state.

The state register uses a four-bit encoding. Its low three bits are the selector's one-hot control and its top bit is the open output, so no decode logic sits between the state and its outputs. One wrong digit at any step sends the lock to an error state. That state is absorbing and only a synchronous reset leaves it. The open state is just as sticky. The combination is fixed by parameters and is loaded into its registers during reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the lock enters the first-digit state (code 0001) on that edge and `unlocked` is 0 afterwards, whatever the state was before.
- R2: The three combination digits come from the parameters `KEY0`, `KEY1` and `KEY2`, with defaults 3, 4 and 2. They are loaded at reset, and digit 1 is compared first.
- R3: In a digit-entry state, a cycle with `strobe` low leaves the state unchanged, so idle cycles of any length between digits are allowed.
- R4: In a digit-entry state, a strobe whose `digit_in` equals the selected digit moves to the next step: 0001 to 0010, 0010 to 0100, and 0100 to open (1000).
- R5: In a digit-entry state, a strobe whose `digit_in` differs from the selected digit moves to the error state (0000), and `unlocked` stays 0.
- R6: The open and error states keep their state under any strobe and digit values until reset. After an error, entering the full correct combination leaves `unlocked` at 0.
- R7: The state is always one of 0001, 0010, 0100, 1000 or 0000. `unlocked` is state bit 3. The select lines are the low three state bits and are all zero in open and error.
- R8: `unlocked` rises on the clock edge that samples the third correct strobe, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | One-cycle pulse that marks a new digit on `digit_in` |
| digit_in | input | DIGIT_W | Entered digit value |
| unlocked | output | 1 | 1 when the lock is open, 0 when closed |

## Verification
The bench builds the lock with `KEY0=9`, `KEY1=0` and `KEY2=15` instead of the defaults. This places the all-zeros and all-ones values of the 4-bit digit inside the combination. A selector or comparator that drops bits, or that passes a zero digit through by accident, therefore gives the wrong answer. Because the three digits are distinct, the bench can tell a lock that compares against the wrong position apart from a correct one. It does this by entering a digit that would be correct one step early.

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int                 DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] KEY0    = 3,
  parameter logic [DIGIT_W-1:0] KEY1    = 4,
  parameter logic [DIGIT_W-1:0] KEY2    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [DIGIT_W-1:0] digit_in,
  output logic               unlocked
);
  localparam int NDIG = 3;
  localparam int SW   = NDIG + 1;
  localparam logic [SW-1:0] ST_FIRST = SW'(1);
  localparam logic [SW-1:0] ST_ERR   = '0;
  localparam logic [DIGIT_W-1:0] KEYS [NDIG] = '{KEY0, KEY1, KEY2};

  logic [SW-1:0]      state, state_d;
  logic [DIGIT_W-1:0] key_q [NDIG];
  logic [DIGIT_W-1:0] term  [NDIG];
  logic [NDIG-1:0]    sel;
  logic [DIGIT_W-1:0] expect_v;
  logic               match;

  assign sel      = state[NDIG-1:0];
  assign unlocked = state[SW-1];

  always_ff @(posedge clk) begin
    if (rst) key_q <= KEYS;
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_gate
    assign term[i] = key_q[i] & {DIGIT_W{sel[i]}};
  end

  always_comb begin
    expect_v = '0;
    for (int i = 0; i < NDIG; i++) expect_v = expect_v | term[i];
  end

  assign match = (expect_v == digit_in);

  always_comb begin
    state_d = state;
    if (strobe && |sel) state_d = match ? (state << 1) : ST_ERR;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FIRST;
    else     state <= state_d;
  end
endmodule

module combo_lock_chk #(
  parameter int                 DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] KEY0    = 3,
  parameter logic [DIGIT_W-1:0] KEY1    = 4,
  parameter logic [DIGIT_W-1:0] KEY2    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               strobe,
  input logic [DIGIT_W-1:0] digit_in,
  input logic               unlocked,
  input logic [3:0]         state
);
  a_r1_reset_first: assert property (@(posedge clk) rst |=> (state == 4'b0001 && !unlocked));
  a_r7_legal_code:  assert property (@(posedge clk) disable iff (rst) $onehot0(state));
  a_r3_idle_hold:   assert property (@(posedge clk) disable iff (rst) !strobe |=> $stable(state));
  a_r6_absorbing:   assert property (@(posedge clk) disable iff (rst)
                      (state == 4'b0000 || state == 4'b1000) |=> $stable(state));
  a_r5_wrong_first: assert property (@(posedge clk) disable iff (rst)
                      (state == 4'b0001 && strobe && digit_in != KEY0) |=> state == 4'b0000);
  a_r4_good_second: assert property (@(posedge clk) disable iff (rst)
                      (state == 4'b0010 && strobe && digit_in == KEY1) |=> state == 4'b0100);
  a_r8_open_rise:   assert property (@(posedge clk) disable iff (rst)
                      $rose(unlocked) |-> ($past(state) == 4'b0100 && $past(strobe) && $past(digit_in) == KEY2));
endmodule

bind combo_lock combo_lock_chk #(.DIGIT_W(DIGIT_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .digit_in(digit_in), .unlocked(unlocked), .state(state)
);

// File: tb/combo_lock_bench.sv
module combo_lock_bench;
  localparam int DW = 4;
  localparam logic [DW-1:0] K0 = 9, K1 = 0, K2 = 15;

  logic clk = 0, rst = 1, strobe = 0;
  logic [DW-1:0] digit_in = '0;
  logic unlocked;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  combo_lock #(.DIGIT_W(DW), .KEY0(K0), .KEY1(K1), .KEY2(K2)) u_combo_lock (
    .clk(clk), .rst(rst), .strobe(strobe), .digit_in(digit_in), .unlocked(unlocked)
  );

  task automatic check(input logic exp, input string req);
    n_run++;
    if (unlocked !== exp) begin
      n_fail++;
      $display("FAIL %s: unlocked=%b expected=%b", req, unlocked, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1; strobe = 0;
    @(negedge clk) rst = 0;
  endtask

  task automatic enter(input logic [DW-1:0] v);
    @(negedge clk) strobe = 1; digit_in = v;
    @(negedge clk) strobe = 0; digit_in = ~v;
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1 closed after reset");
  endtask

  task automatic t_correct();
    do_reset();
    enter(K0); check(1'b0, "R4 step1");
    enter(K1); check(1'b0, "R4 step2");
    enter(K2); check(1'b1, "R8 open after third digit");
  endtask

  task automatic t_wrong(input int pos);
    logic [DW-1:0] seq [3];
    seq = '{K0, K1, K2};
    do_reset();
    for (int i = 0; i < pos; i++) enter(seq[i]);
    enter(seq[(pos + 1) % 3]);
    check(1'b0, "R5 closed after wrong digit");
    for (int i = 0; i < 3; i++) enter(seq[i]);
    check(1'b0, "R6 error absorbs later correct digits");
  endtask

  task automatic t_idle();
    do_reset();
    repeat (5) @(negedge clk);
    enter(K0);
    repeat (7) @(negedge clk);
    check(1'b0, "R3 idle between digits");
    enter(K1);
    repeat (3) @(negedge clk);
    enter(K2);
    check(1'b1, "R3 idle gaps do not break sequence");
  endtask

  task automatic t_open_sticky();
    do_reset();
    enter(K0); enter(K1); enter(K2);
    enter(4'd5); enter(K0);
    repeat (4) @(negedge clk);
    check(1'b1, "R6 open holds under strobes");
    do_reset();
    check(1'b0, "R1 reset leaves open");
    enter(K0); enter(K1); enter(K2);
    check(1'b1, "R2 combination reloaded after reset");
  endtask

  task automatic t_default_key_rejected();
    do_reset();
    enter(4'd3); enter(4'd4); enter(4'd2);
    check(1'b0, "R2 keys taken from parameters");
  endtask

  task automatic t_early_open_check();
    do_reset();
    enter(K0); enter(K1);
    @(negedge clk) strobe = 1; digit_in = K2;
    check(1'b0, "R8 not open before edge");
    @(negedge clk) strobe = 0;
    check(1'b1, "R8 open right after edge");
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1'b0, "R1 closed during reset");
    t_reset();
    t_correct();
    for (int p = 0; p < 3; p++) t_wrong(p);
    t_idle();
    t_open_sticky();
    t_default_key_rejected();
    t_early_open_check();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule